// File: doc/BRIEF.md
# Vectored IRQ Address Port

This block sits on the processor side of a link to an external vectored interrupt controller. It accepts the controller's active-low normal and fast interrupt request lines and delivers them to the core as active-high pending flags. Each line passes through a two-stage synchronizer unless a strap selects the synchronous path. When the core starts normal (IRQ) interrupt entry, the block fetches the handler address from the controller through an acknowledge/valid handshake. The valid line has its own synchronizer and its own bypass strap.

The core side is a plain request/done pair. An IRQ entry request with the port enabled raises the acknowledge. The block waits for the synchronized valid, latches the word-aligned handler address and pulses done for one cycle. With the port disabled, or for any FIQ entry, the block skips the handshake. In that case it returns a fixed vector in the same cycle as the request. The fixed vector sits at offset 0x18 for IRQ and 0x1C for FIQ, from a base of zero or of 0xFFFF0000 when high vectors are selected. The returned address stays on the output until the next request.

Top module: `irq_vector_port`

## Requirements
- R1: `irq_req_n_i` and `fiq_req_n_i` are active low. `irq_pend_o` and `fiq_pend_o` are 1 when the matching input is 0.
- R2: With `int_sync_byp_i`=1 a pending flag follows its request input in the same cycle. With `int_sync_byp_i`=0 the flag changes after the second rising clock edge that follows the input change.
- R3: Measured from the cycle in which `vec_vld_i` rises while `ack_o` is 1, `entry_done_o` rises after 1 clock edge when `vld_sync_byp_i`=1 and after 3 clock edges when `vld_sync_byp_i`=0.
- R4: An IRQ entry request in the idle state with `port_en_i`=1 sets `ack_o` on the next edge. `ack_o` stays 1 until the synchronized valid is seen, and it falls on the same edge that raises `entry_done_o`.
- R5: On a handshake, `handler_addr_o` = {`vec_addr_i`, 2'b00}, captured while the valid is high. `entry_done_o` is a one-cycle pulse.
- R6: With `port_en_i`=0, an idle IRQ entry request gives `entry_done_o`=1 in the same cycle, never raises `ack_o`, and returns 0x00000018, or 0xFFFF0018 when `hi_vec_i`=1.
- R7: An idle FIQ entry request always gives `entry_done_o` in the same cycle with 0x0000001C, or 0xFFFF001C when `hi_vec_i`=1, and never raises `ack_o`. This holds even with `port_en_i`=1. FIQ wins when both entry requests arrive together.
- R8: Entry requests that arrive while a handshake is in progress are ignored. No new `ack_o` is raised until the synchronized valid has fallen.
- R9: `handler_addr_o` stays stable between completions, until the next entry request.
- R10: During reset `ack_o`=0, `entry_done_o`=0, `handler_addr_o`=0 and both pending flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_n_i | input | 1 | Normal interrupt request, active low |
| fiq_req_n_i | input | 1 | Fast interrupt request, active low |
| int_sync_byp_i | input | 1 | 1 bypasses both request synchronizers |
| vld_sync_byp_i | input | 1 | 1 bypasses the valid synchronizer |
| port_en_i | input | 1 | 1 uses the handshake for IRQ entry |
| hi_vec_i | input | 1 | Selects base 0xFFFF0000 for fixed vectors |
| irq_pend_o | output | 1 | Synchronized IRQ pending, active high |
| fiq_pend_o | output | 1 | Synchronized FIQ pending, active high |
| irq_entry_i | input | 1 | Core requests IRQ entry (one-cycle pulse) |
| fiq_entry_i | input | 1 | Core requests FIQ entry (one-cycle pulse) |
| ack_o | output | 1 | Acknowledge to the controller, active high |
| vec_vld_i | input | 1 | Handler address valid, active high |
| vec_addr_i | input | 30 | Handler address bits [31:2] |
| handler_addr_o | output | 32 | Returned handler address |
| entry_done_o | output | 1 | Entry address ready (one-cycle pulse) |

## Verification
The assertions assume that the controller raises valid only in answer to a raised acknowledge. They also assume it holds the address steady while valid is high and lowers valid before the next acknowledge could start. The core is assumed to send entry requests as single-cycle pulses. The stimulus drives valid only after it has seen `ack_o` high, drops it after done, and then waits long enough for the synchronized copy to clear before it issues a new request. Requests are always one cycle wide.

// File: rtl/irq_vector_port.sv
module irq_vector_port #(
  parameter int ADDR_W = 32,
  parameter int SYNC_LEN = 2,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] IRQ_OFS = 32'h18,
  parameter logic [ADDR_W-1:0] FIQ_OFS = 32'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_n_i,
  input  logic              fiq_req_n_i,
  input  logic              int_sync_byp_i,
  input  logic              vld_sync_byp_i,
  input  logic              port_en_i,
  input  logic              hi_vec_i,
  output logic              irq_pend_o,
  output logic              fiq_pend_o,
  input  logic              irq_entry_i,
  input  logic              fiq_entry_i,
  output logic              ack_o,
  input  logic              vec_vld_i,
  input  logic [ADDR_W-3:0] vec_addr_i,
  output logic [ADDR_W-1:0] handler_addr_o,
  output logic              entry_done_o
);
  localparam int LAST = SYNC_LEN - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_CAPT, ST_VLOW} st_e;
  st_e st_q;

  logic [LAST:0] irq_sh, fiq_sh, vld_sh;
  logic vld_s, legacy_now;
  logic [ADDR_W-1:0] addr_q, legacy_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sh <= '1;
      fiq_sh <= '1;
      vld_sh <= '0;
    end else begin
      irq_sh <= {irq_sh[LAST-1:0], irq_req_n_i};
      fiq_sh <= {fiq_sh[LAST-1:0], fiq_req_n_i};
      vld_sh <= {vld_sh[LAST-1:0], vec_vld_i};
    end
  end

  assign irq_pend_o = int_sync_byp_i ? !irq_req_n_i : !irq_sh[LAST];
  assign fiq_pend_o = int_sync_byp_i ? !fiq_req_n_i : !fiq_sh[LAST];
  assign vld_s      = vld_sync_byp_i ? vec_vld_i : vld_sh[LAST];

  assign legacy_now  = (st_q == ST_IDLE) && (fiq_entry_i || (irq_entry_i && !port_en_i));
  assign legacy_addr = (hi_vec_i ? HI_BASE : '0) + (fiq_entry_i ? FIQ_OFS : IRQ_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:
          if (legacy_now) addr_q <= legacy_addr;
          else if (irq_entry_i && port_en_i) st_q <= ST_ACK;
        ST_ACK:
          if (vld_s) begin
            addr_q <= {vec_addr_i, 2'b00};
            st_q   <= ST_CAPT;
          end
        ST_CAPT: st_q <= ST_VLOW;
        default: if (!vld_s) st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o          = (st_q == ST_ACK);
  assign entry_done_o   = (st_q == ST_CAPT) || legacy_now;
  assign handler_addr_o = legacy_now ? legacy_addr : addr_q;

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !vld_s |=> ack_o); // R4
  AST_ACK_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && vld_s |=> !ack_o && entry_done_o); // R4
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done_o |-> handler_addr_o[1:0] == 2'b00); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done_o && !legacy_now |=> !entry_done_o || legacy_now); // R5
  AST_NO_REACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o && vld_s |=> !ack_o); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o && !irq_entry_i && !fiq_entry_i |=> $stable(addr_q)); // R9
  AST_FIQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_entry_i && !ack_o |=> !ack_o); // R7
endmodule

// File: tb/irq_vector_port_test.sv
module irq_vector_port_test;
  logic clk = 0, rst_n = 0;
  logic irq_n = 1, fiq_n = 1, int_byp = 0, vld_byp = 0, en = 0, hi = 0;
  logic irq_e = 0, fiq_e = 0, vld = 0;
  logic [29:0] vaddr = '0;
  logic irq_p, fiq_p, ack, done;
  logic [31:0] haddr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_vector_port uut (
    .clk(clk), .rst_n(rst_n), .irq_req_n_i(irq_n), .fiq_req_n_i(fiq_n),
    .int_sync_byp_i(int_byp), .vld_sync_byp_i(vld_byp), .port_en_i(en), .hi_vec_i(hi),
    .irq_pend_o(irq_p), .fiq_pend_o(fiq_p), .irq_entry_i(irq_e), .fiq_entry_i(fiq_e),
    .ack_o(ack), .vec_vld_i(vld), .vec_addr_i(vaddr),
    .handler_addr_o(haddr), .entry_done_o(done));

  // {en, hi, fiq, vld_byp, vec_addr[29:0], expected address, latency}
  localparam logic [67:0] TBL [7] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 30'h0000_1000, 32'h0000_4000, 2'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 30'h3FFF_FFFF, 32'hFFFF_FFFC, 2'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 30'h1234_5678, 32'h0000_0018, 2'd0},
    {1'b0, 1'b1, 1'b0, 1'b1, 30'h1234_5678, 32'hFFFF_0018, 2'd0},
    {1'b1, 1'b0, 1'b1, 1'b1, 30'h1234_5678, 32'h0000_001C, 2'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 30'h1234_5678, 32'hFFFF_001C, 2'd0},
    {1'b1, 1'b0, 1'b0, 1'b0, 30'h2AAA_AAAA, 32'hAAAA_AAA8, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_entry(input logic [67:0] v);
    int n;
    @(negedge clk);
    en = v[67]; hi = v[66]; vld_byp = v[64]; vaddr = v[63:34];
    if (v[65]) fiq_e = 1; else irq_e = 1;
    #1;
    if (v[1:0] == 0) begin
      chk(v[65] ? "R7 done" : "R6 done", done, 1);
      chk(v[65] ? "R7 addr" : "R6 addr", haddr, v[33:2]);
      @(negedge clk); irq_e = 0; fiq_e = 0; #1;
      chk(v[65] ? "R7 no ack" : "R6 no ack", ack, 0);
      chk("R5 done pulse", done, 0);
      chk("R9 addr held", haddr, v[33:2]);
    end else begin
      @(negedge clk); irq_e = 0;
      repeat (3) @(negedge clk);
      chk("R4 ack held", ack, 1);
      vld = 1;
      n = 0;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (done) break;
      end
      chk("R3 latency", n, v[1:0]);
      chk("R5 addr", haddr, v[33:2]);
      chk("R4 ack dropped", ack, 0);
      @(negedge clk);
      chk("R5 done pulse", done, 0);
      vld = 0;
      repeat (4) @(negedge clk);
      chk("R8 no reack", ack, 0);
      chk("R9 addr held", haddr, v[33:2]);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 ack", ack, 0);
    chk("R10 done", done, 0);
    chk("R10 addr", haddr, 0);
    chk("R10 pend", {irq_p, fiq_p}, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (TBL[i]) run_entry(TBL[i]);

    // R1 R2: bypassed request path
    int_byp = 1; irq_n = 0; #1;
    chk("R1 irq pend bypass", irq_p, 1);
    // R2: synchronized path takes two edges
    @(negedge clk); int_byp = 0; fiq_n = 0;
    @(negedge clk);
    chk("R2 fiq pend after one edge", fiq_p, 0);
    @(negedge clk);
    chk("R2 fiq pend after two edges", fiq_p, 1);
    chk("R1 irq pend sync", irq_p, 1);
    irq_n = 1; fiq_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 pend cleared", {irq_p, fiq_p}, 0);

    // R7: FIQ wins when both arrive together
    en = 1; hi = 0; irq_e = 1; fiq_e = 1; #1;
    chk("R7 priority addr", haddr, 32'h1C);
    @(negedge clk); irq_e = 0; fiq_e = 0;
    chk("R7 priority no ack", ack, 0);

    // R8: requests during a handshake are ignored
    vld_byp = 1; vaddr = 30'h0000_0400;
    irq_e = 1; @(negedge clk); irq_e = 0;
    chk("R4 ack rise", ack, 1);
    fiq_e = 1; #1;
    chk("R8 fiq ignored done", done, 0);
    @(negedge clk); fiq_e = 0;
    chk("R8 fiq ignored addr", haddr, 32'h1C);
    vld = 1;
    @(negedge clk);
    chk("R5 addr second", haddr, 32'h0000_1000);
    @(negedge clk);
    irq_e = 1; @(negedge clk); irq_e = 0;
    repeat (2) @(negedge clk);
    chk("R8 no ack while valid high", ack, 0);
    vld = 0;
    repeat (3) @(negedge clk);
    chk("R8 dropped request", ack, 0);
    chk("R9 addr kept", haddr, 32'h0000_1000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule